// File: doc/BRIEF.md
# Multiplexed ADC Input Sequencer

This block steps a four-slot analog input multiplexer in front of a single shared converter and decimation filter. Each compute-engine pass start opens a frame. For each slot the block drives the multiplexer select, pulses the filter start, and waits for the filter's done strobe. It then stores the decimated result in the data RAM word that belongs to the selected channel.

Two frame kinds exist. A regular frame samples both current inputs and both voltage inputs. An alternate frame, which the host requests now and then, puts the die temperature sensor and the battery monitor in the two current slots. The voltage-A input keeps slot 1 in both kinds, so downstream voltage tracking never loses a sample. The battery load resistor is switched on only when the host has enabled battery monitoring.

The block runs from the slow timebase clock. The converter and the filter arithmetic sit outside it.

Top module: `adc_input_sequencer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `muxSel` shows the idle code 7, and `firStart`, `ramWrEn`, `frameDone` and `batLoadEn` are low.
- R2: A regular frame selects channel codes IA=0, VA=1, IB=2, VB=3 in slot order 0,1,2,3. The code appears on `muxSel` in the same cycle as that slot's `firStart` pulse.
- R3: An alternate frame selects TEMP=4, VA=1, VBAT=5, VB=3 in slot order. Slot 1 is VA in both frame kinds.
- R4: An `altReq` pulse is held pending and affects only the next frame that starts afterwards. A frame already running is not changed. The pending request clears when the alternate frame completes, so the following frame is regular.
- R5: The block moves to the next slot only on `convDone`. Each slot gives exactly one `firStart` pulse and one RAM write. The write appears in the cycle after `convDone` is sampled.
- R6: `batLoadEn` is high only during slot 2 of an alternate frame, and only while `batMonEn` is 1. With `batMonEn` at 0, the slot still selects VBAT and still stores a sample, but the load stays off.
- R7: The write address is `RAM_BASE` (default 16) plus the channel code of the slot that was sampled.
- R8: The write data is the converter word justified at bit 0 and shifted left by 9 bits, with zeros below. With `res22`=0, bit 21 of the input is cleared, giving 21-bit resolution.
- R9: A `frameStart` that arrives while a frame is running is ignored. It does not restart or queue a frame.
- R10: `frameDone` pulses for one cycle, in the same cycle as the slot-3 write. `muxSel` then returns to idle.
- R11: A `convDone` that arrives while no frame is running produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Compute-engine pass start strobe |
| altReq | input | 1 | Host pulse requesting an alternate frame |
| batMonEn | input | 1 | Battery monitor enable |
| res22 | input | 1 | 1 selects 22-bit results, 0 selects 21-bit results |
| convDone | input | 1 | Filter done strobe for the current slot |
| convData | input | 22 | Decimated converter result |
| muxSel | output | 3 | Channel select code (7 when idle) |
| firStart | output | 1 | One-cycle filter start per slot |
| batLoadEn | output | 1 | Battery load resistor enable |
| frameDone | output | 1 | One-cycle pulse at the end of a frame |
| ramWrEn | output | 1 | RAM write enable |
| ramWrAddr | output | 9 | RAM write address |
| ramWrData | output | 32 | RAM write data |

## Verification
The checker tests these rules on every cycle:
- The battery load is gated by the enable and by the VBAT selection.
- Each accepted done strobe produces exactly one write in the next cycle, and every write has a preceding done strobe.
- The low nine data bits are zero on every write.
- Filter starts happen only inside a frame, and the end-of-frame pulse coincides with a return to idle.

Only the directed scenarios can show the rest:
- The slot order for each frame kind, and the mapping of each slot to its RAM address.
- That an alternate request waits for the next frame and then clears itself.
- Masking at 21-bit resolution.
- That stray frame starts and stray done strobes are ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CHAN_W = 3;

  typedef enum logic [CHAN_W-1:0] {
    CH_IA   = 3'd0,
    CH_VA   = 3'd1,
    CH_IB   = 3'd2,
    CH_VB   = 3'd3,
    CH_TEMP = 3'd4,
    CH_VBAT = 3'd5,
    CH_IDLE = 3'd7
  } chan_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;
    chan_t chan;
  } seq_strobe_t;

  function automatic chan_t slotChan(input logic alt, input logic [1:0] slot);
    chan_t c;
    case (slot)
      2'd0:    c = alt ? CH_TEMP : CH_IA;
      2'd1:    c = CH_VA;
      2'd2:    c = alt ? CH_VBAT : CH_IB;
      default: c = CH_VB;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        altReq,
  input  logic        batMonEn,
  input  logic        convDone,
  output chan_t       muxSel,
  output logic        firStart,
  output logic        frameDone,
  output logic        batLoadEn,
  output seq_strobe_t strb
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W-1:0] BAT_SLOT  = SLOT_W'(2);

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic              altFrame;
  logic              altPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      slot      <= '0;
      altFrame  <= 1'b0;
      altPend   <= 1'b0;
      firStart  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      firStart  <= 1'b0;
      frameDone <= 1'b0;
      if (altReq) altPend <= 1'b1;
      if (!busy) begin
        if (frameStart) begin
          busy     <= 1'b1;
          slot     <= '0;
          altFrame <= altPend;
          firStart <= 1'b1;
        end
      end else if (convDone) begin
        if (slot == LAST_SLOT) begin
          busy      <= 1'b0;
          frameDone <= 1'b1;
          if (altFrame && !altReq) altPend <= 1'b0;
        end else begin
          slot     <= slot + 1'b1;
          firStart <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    muxSel       = busy ? slotChan(altFrame, 2'(slot)) : CH_IDLE;
    batLoadEn    = busy && altFrame && (slot == BAT_SLOT) && batMonEn;
    strb.capture = busy && convDone;
    strb.chan    = muxSel;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int DATA_W   = 22,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 9,
  parameter int RAM_BASE = 16,
  parameter int SHIFT    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              res22,
  input  logic [DATA_W-1:0] convData,
  input  seq_strobe_t       strb,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [WORD_W-1:0] ramWrData
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked;

  // top bit of the converter word kept only at full resolution
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi == DATA_W - 1) begin : g_top
        assign mask[gi] = res22;
      end else begin : g_low
        assign mask[gi] = 1'b1;
      end
    end
  endgenerate

  assign masked = convData & mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramWrEn   <= 1'b0;
      ramWrAddr <= '0;
      ramWrData <= '0;
    end else begin
      ramWrEn <= strb.capture;
      if (strb.capture) begin
        ramWrAddr <= BASE_A + ADDR_W'(strb.chan);
        ramWrData <= WORD_W'(masked) << SHIFT;
      end
    end
  end
endmodule

// File: rtl/adc_input_sequencer.sv
module adc_input_sequencer
  import seq_pkg::*;
#(
  parameter int DATA_W   = 22,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 9,
  parameter int RAM_BASE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              altReq,
  input  logic              batMonEn,
  input  logic              res22,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic [2:0]        muxSel,
  output logic              firStart,
  output logic              batLoadEn,
  output logic              frameDone,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [WORD_W-1:0] ramWrData
);
  seq_strobe_t strb;
  chan_t       chanSel;

  seq_ctrl #(.NUM_SLOTS(4)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .altReq(altReq),
    .batMonEn(batMonEn), .convDone(convDone), .muxSel(chanSel),
    .firStart(firStart), .frameDone(frameDone), .batLoadEn(batLoadEn),
    .strb(strb)
  );

  seq_datapath #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .RAM_BASE(RAM_BASE), .SHIFT(9)
  ) dp_i (
    .clk(clk), .rstN(rstN), .res22(res22), .convData(convData), .strb(strb),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData)
  );

  assign muxSel = chanSel;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              batMonEn,
  input logic              convDone,
  input logic [2:0]        muxSel,
  input logic              firStart,
  input logic              batLoadEn,
  input logic              frameDone,
  input logic              ramWrEn,
  input logic [WORD_W-1:0] ramWrData
);
  // R6
  a_r6_batload_gated: assert property (@(posedge clk) disable iff (!rstN)
    batLoadEn |-> (batMonEn && muxSel == 3'd5));
  // R5
  a_r5_done_gives_write: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && muxSel != 3'd7) |=> ramWrEn);
  // R11
  a_r11_write_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> ($past(convDone) && $past(muxSel) != 3'd7));
  // R8
  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (ramWrData[8:0] == 9'd0));
  // R1
  a_r1_start_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    firStart |-> (muxSel != 3'd7));
  // R10
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (muxSel == 3'd7 && ramWrEn));
endmodule

bind adc_input_sequencer seq_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .batMonEn(batMonEn), .convDone(convDone),
  .muxSel(muxSel), .firStart(firStart), .batLoadEn(batLoadEn),
  .frameDone(frameDone), .ramWrEn(ramWrEn), .ramWrData(ramWrData)
);

// File: tb/adc_input_sequencer_tb.sv
module adc_input_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FIR_DLY    = 3;
  localparam int BASE       = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0, altReq = 1'b0, batMonEn = 1'b0, res22 = 1'b1;
  logic        stubDone = 1'b0, tbDone = 1'b0;
  logic [21:0] convData = '0;
  logic [2:0]  muxSel;
  logic        firStart, batLoadEn, frameDone, ramWrEn;
  logic [8:0]  ramWrAddr;
  logic [31:0] ramWrData;

  int tests = 0, fails = 0;
  int stubCnt = 0, stubSeq = 0;
  int logCnt = 0, selCnt = 0, doneCnt = 0, batSeen = 0;
  logic [8:0]  logAddr [0:7];
  logic [31:0] logData [0:7];
  logic [21:0] sentData [0:7];
  logic [2:0]  logSel [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_input_sequencer dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .altReq(altReq),
    .batMonEn(batMonEn), .res22(res22), .convDone(stubDone | tbDone),
    .convData(convData), .muxSel(muxSel), .firStart(firStart),
    .batLoadEn(batLoadEn), .frameDone(frameDone), .ramWrEn(ramWrEn),
    .ramWrAddr(ramWrAddr), .ramWrData(ramWrData)
  );

  // converter and filter stand-in
  always @(negedge clk) begin
    stubDone <= 1'b0;
    if (stubCnt != 0) begin
      stubCnt <= stubCnt - 1;
      if (stubCnt == 1) begin
        stubDone <= 1'b1;
        convData <= 22'h2AAAA0 + 22'(stubSeq * 37);
        if (logCnt < 8) sentData[logCnt] <= 22'h2AAAA0 + 22'(stubSeq * 37);
        stubSeq  <= stubSeq + 1;
      end
    end else if (firStart) begin
      stubCnt <= FIR_DLY;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (ramWrEn && logCnt < 8) begin
      logAddr[logCnt] <= ramWrAddr;
      logData[logCnt] <= ramWrData;
      logCnt <= logCnt + 1;
    end
    if (firStart && selCnt < 8) begin
      logSel[selCnt] <= muxSel;
      selCnt <= selCnt + 1;
    end
    if (frameDone) doneCnt <= doneCnt + 1;
    if (batLoadEn) batSeen <= batSeen + 1;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearLogs();
    @(negedge clk);
    logCnt = 0; selCnt = 0; doneCnt = 0; batSeen = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
  endtask

  task automatic waitDone();
    int seen = doneCnt;
    while (doneCnt == seen) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] expChan(input bit alt, input int s);
    case (s)
      0: return alt ? 3'd4 : 3'd0;
      1: return 3'd1;
      2: return alt ? 3'd5 : 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic [31:0] expWord(input logic [21:0] d, input bit r22);
    logic [21:0] m = r22 ? d : (d & 22'h1FFFFF);
    return {1'b0, m, 9'd0};
  endfunction

  // checks frame at log offset off
  task automatic checkFrame(input string tag, input bit alt, input int off, input bit r22);
    for (int s = 0; s < 4; s++) begin
      check({tag, " R2/R3 slot order"}, logSel[off+s], expChan(alt, s));
      check({tag, " R7 address"}, logAddr[off+s], BASE + expChan(alt, s));
      check({tag, " R8 data"}, logData[off+s], expWord(sentData[off+s], r22));
    end
  endtask

  task automatic testReset();
    check("R1 idle select", muxSel, 7);
    check("R1 no write", ramWrEn, 0);
    check("R1 no start", firStart, 0);
    check("R1 no load", batLoadEn, 0);
  endtask

  task automatic testRegularPair();
    clearLogs();
    pulseStart(); waitDone();
    pulseStart(); waitDone();
    check("R5 writes per two frames", logCnt, 8);
    check("R10 done pulses", doneCnt, 2);
    check("R1 idle after frame", muxSel, 7);
    checkFrame("regular A", 1'b0, 0, 1'b1);
    checkFrame("regular B", 1'b0, 4, 1'b1);
  endtask

  task automatic testAltMidFrame();
    clearLogs();
    batMonEn = 1'b1;
    pulseStart();
    repeat (2) @(negedge clk);
    altReq = 1'b1; @(negedge clk); altReq = 1'b0;
    waitDone();
    checkFrame("R4 running frame unchanged", 1'b0, 0, 1'b1);
    check("R6 no load in regular", batSeen, 0);
    clearLogs();
    pulseStart(); waitDone();
    checkFrame("R3 alt frame", 1'b1, 0, 1'b1);
    check("R6 load cycles with enable", batSeen, FIR_DLY + 1);
    clearLogs();
    pulseStart(); waitDone();
    checkFrame("R4 self-clear regular", 1'b0, 0, 1'b1);
  endtask

  task automatic testAltNoBat();
    clearLogs();
    batMonEn = 1'b0;
    altReq = 1'b1; @(negedge clk); altReq = 1'b0;
    pulseStart(); waitDone();
    checkFrame("R6 alt no bat", 1'b1, 0, 1'b1);
    check("R6 load off when disabled", batSeen, 0);
  endtask

  task automatic testRes21();
    clearLogs();
    res22 = 1'b0;
    pulseStart(); waitDone();
    checkFrame("R8 21-bit", 1'b0, 0, 1'b0);
    check("R8 bit30 cleared", logData[0][30], 0);
    res22 = 1'b1;
  endtask

  task automatic testBusyStart();
    clearLogs();
    pulseStart();
    repeat (3) @(negedge clk);
    pulseStart();
    waitDone();
    repeat (FIR_DLY + 4) @(negedge clk);
    check("R9 writes from one frame", logCnt, 4);
    check("R9 starts from one frame", selCnt, 4);
    check("R9 idle after", muxSel, 7);
  endtask

  task automatic testIdleDone();
    clearLogs();
    @(negedge clk); tbDone = 1'b1;
    @(negedge clk); tbDone = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 no idle write", logCnt, 0);
    check("R11 still idle", muxSel, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testRegularPair();
    testAltMidFrame();
    testAltNoBat();
    testRes21();
    testBusyStart();
    testIdleDone();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule